// File: doc/BRIEF.md
# ADC output bit mapper and serializer

This block sits between a converter channel pair and the chip's output pads. Each 16-bit sample, taken either straight from the converter or from the decimation filter, is formatted to an output resolution of 14, 16, 18 or 20 bits. The block then either shifts the result out on one or two double-data-rate lanes, with a frame clock and a bit clock, or presents it as a parallel word.

All timing is derived from one fast clock plus a bit-slot enable `bit_en_i`. Each enabled cycle is one lane bit slot, which is half a bit-clock period. The block pulls samples: `take_o` tells the source that the samples on the inputs are captured at the current edge. Resolution, lane mode and source are sampled only when a frame starts. A frame in flight therefore always finishes in the format it began with.

Top module: `adc_out_mapper`

## Requirements
- R1: Resolution code `res_sel_i` selects the output format: 0 gives 14 bits (the two input LSBs dropped), 1 gives 16 bits (the sample as is), 2 gives 18 bits and 3 gives 20 bits (the sample in the upper bits, zeros below). Serial bits leave MSB first.
- R2: Lane code `lane_mode_i` selects the lane arrangement. In code 0 (dual), a frame holds two consecutive channel-0 samples; for each sample, `d0_o` carries its upper half bits and `d1_o` its lower half. In code 1 (single), one channel-0 sample goes on `d0_o`. In code 2 (shared), the channel-0 sample and then the channel-1 sample go on `d0_o`. In codes 1 and 2, `d1_o` stays low.
- R3: In lane code 3 (parallel), resolution codes 2 and 3 act as code 1. `par_o` is loaded at each frame start with the word right-justified: 16 bits give the sample, and 14 bits give two zero MSBs followed by sample bits 15..2.
- R4: The frame length in bit slots is R for dual and single, 2R for shared, and 2 for parallel, where R is the resolution. `fclk_o` rises with the first bit of a frame and stays high for R/2, R/2, R and 1 slots respectively.
- R5: `dclk_o` is high in even slots of a frame (counting from 0) and low in odd slots. This gives two lane bits per bit-clock period.
- R6: Resolution, lane mode and source select are captured only at a frame start. A change made mid-frame does not alter the frame in progress.
- R7: `src_sel_i`=0 takes the bypass inputs and 1 takes the filtered inputs, through the same formatting path.
- R8: `take_o` is high only in enabled cycles in which the block captures samples. That happens once per frame, plus once more mid-frame in dual mode.
- R9: In cycles without `bit_en_i`, all outputs hold their values.
- R10: After reset, all lane, clock and parallel outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One lane bit slot per enabled cycle |
| raw0_i | input | SMP_W | Channel 0 bypass sample |
| raw1_i | input | SMP_W | Channel 1 bypass sample |
| flt0_i | input | SMP_W | Channel 0 filtered sample |
| flt1_i | input | SMP_W | Channel 1 filtered sample |
| src_sel_i | input | 1 | 0 bypass, 1 filtered |
| lane_mode_i | input | 2 | 0 dual, 1 single, 2 shared, 3 parallel |
| res_sel_i | input | 2 | 0:14, 1:16, 2:18, 3:20 bits |
| take_o | output | 1 | Samples captured at this edge |
| fclk_o | output | 1 | Frame clock |
| dclk_o | output | 1 | Bit clock |
| d0_o | output | 1 | Lane 0 data |
| d1_o | output | 1 | Lane 1 data |
| par_o | output | SMP_W | Parallel output word |

## Verification
The bench builds the block with its default sample width of 16. The counter width is derived from that, so frames reach the 40-slot worst case of 20-bit shared mode. That default also places every one of the 14, 16, 18 and 20-bit formats, with their truncation and zero padding, in all four lane modes and with both sources. The bit-slot enable is thinned at random, so held outputs are observed. Bursts of mid-frame configuration changes stress the frame-boundary latching.

// File: rtl/adc_map_pkg.sv
package adc_map_pkg;
  typedef enum logic [1:0] {
    RES_NARROW = 2'd0,
    RES_NATIVE = 2'd1,
    RES_WIDE2  = 2'd2,
    RES_WIDE4  = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    LM_DUAL   = 2'd0,
    LM_SINGLE = 2'd1,
    LM_SHARED = 2'd2,
    LM_PAR    = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/adc_map_fmt.sv
module adc_map_fmt
  import adc_map_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int WORD_W = SMP_W + 4
) (
  input  logic [SMP_W-1:0]  smp_i,
  input  res_e              res_i,
  output logic [WORD_W-1:0] word_o
);
  logic [7:0]        keep;
  logic [WORD_W-1:0] full;
  logic [WORD_W-1:0] mask;

  // left-aligned container, keep the top 'keep' bits
  always_comb begin
    keep   = 8'(SMP_W - 2 + 2 * int'(res_i));
    full   = {smp_i, {(WORD_W - SMP_W){1'b0}}};
    mask   = ~({WORD_W{1'b1}} >> keep);
    word_o = full & mask;
  end
endmodule

// File: rtl/adc_map_ctrl.sv
module adc_map_ctrl
  import adc_map_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int CNT_W = $clog2(2 * (SMP_W + 4) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  lane_mode_e       mode_i,
  input  res_e             res_i,
  input  logic             src_i,
  output lane_mode_e       mode_o,
  output res_e             res_o,
  output logic             src_o,
  output lane_mode_e       cur_mode_o,
  output logic             load_o,
  output logic             mid_o,
  output logic             swap_o,
  output logic [CNT_W-1:0] half_o,
  output logic             take_o,
  output logic             fclk_o,
  output logic             dclk_o
);
  lane_mode_e       mode_q;
  res_e             res_q;
  logic             src_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fclk_q, dclk_q;

  logic             start_c;
  res_e             res_in_c;
  lane_mode_e       mode_c;
  res_e             res_c;
  logic [CNT_W-1:0] bits_c, half_c, len_c, hi_c, cnt_nx_c;

  always_comb begin
    start_c  = (cnt_q == '0);
    res_in_c = res_i;
    if (mode_i == LM_PAR && res_i > RES_NATIVE) res_in_c = RES_NATIVE;
    // frame start uses the live settings, otherwise the latched ones
    mode_c = start_c ? mode_i : mode_q;
    res_c  = start_c ? res_in_c : res_q;
    bits_c = CNT_W'(SMP_W - 2 + 2 * int'(res_c));
    half_c = bits_c >> 1;
    case (mode_c)
      LM_DUAL, LM_SINGLE: begin len_c = bits_c;      hi_c = half_c; end
      LM_SHARED:          begin len_c = bits_c << 1; hi_c = bits_c; end
      default:            begin len_c = CNT_W'(2);   hi_c = CNT_W'(1); end
    endcase
    cnt_nx_c = (cnt_q + 1'b1 == len_c) ? '0 : cnt_q + 1'b1;
  end

  assign mode_o     = mode_c;
  assign res_o      = res_c;
  assign src_o      = start_c ? src_i : src_q;
  assign cur_mode_o = mode_q;
  assign load_o     = start_c;
  assign mid_o      = !start_c && mode_c == LM_DUAL && cnt_q == half_c;
  assign swap_o     = !start_c && mode_c == LM_SHARED && cnt_q == bits_c;
  assign half_o     = half_c;
  assign take_o     = bit_en_i && (start_c || mid_o);
  assign fclk_o     = fclk_q;
  assign dclk_o     = dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LM_SINGLE;
      res_q  <= RES_NATIVE;
      src_q  <= 1'b0;
      cnt_q  <= '0;
      fclk_q <= 1'b0;
      dclk_q <= 1'b0;
    end else if (bit_en_i) begin
      if (start_c) begin
        mode_q <= mode_i;
        res_q  <= res_in_c;
        src_q  <= src_i;
      end
      cnt_q  <= cnt_nx_c;
      fclk_q <= (cnt_q < hi_c);
      dclk_q <= ~cnt_q[0];
    end
  end

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && cnt_q != '0 |=> mode_q == $past(mode_q) && res_q == $past(res_q)
                                && src_q == $past(src_q));

  p_par_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == LM_PAR |-> (res_q == RES_NARROW || res_q == RES_NATIVE));

  p_dclk_alt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> dclk_o != $past(dclk_o));
endmodule

// File: rtl/adc_map_lanes.sv
module adc_map_lanes
  import adc_map_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int WORD_W = SMP_W + 4,
  parameter int CNT_W  = $clog2(2 * WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              load_i,
  input  logic              mid_i,
  input  logic              swap_i,
  input  lane_mode_e        mode_i,
  input  res_e              res_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  output logic              d0_o,
  output logic              d1_o,
  output logic [SMP_W-1:0]  par_o
);
  logic [WORD_W-1:0] sh0_q, sh1_q, hold_q;
  logic [SMP_W-1:0]  par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh0_q  <= '0;
      sh1_q  <= '0;
      hold_q <= '0;
      par_q  <= '0;
    end else if (bit_en_i) begin
      if (load_i || mid_i) begin
        case (mode_i)
          LM_DUAL: begin
            sh0_q <= word0_i;
            sh1_q <= word0_i << half_i;  // lower half rides lane 1
          end
          LM_SINGLE: begin
            sh0_q <= word0_i;
            sh1_q <= '0;
          end
          LM_SHARED: begin
            sh0_q  <= word0_i;
            sh1_q  <= '0;
            hold_q <= word1_i;
          end
          default: begin
            sh0_q <= '0;
            sh1_q <= '0;
            par_q <= (res_i == RES_NARROW) ? {2'b00, word0_i[WORD_W-1 -: SMP_W-2]}
                                           : word0_i[WORD_W-1 -: SMP_W];
          end
        endcase
      end else if (swap_i) begin
        sh0_q <= hold_q;
        sh1_q <= sh1_q << 1;
      end else begin
        sh0_q <= sh0_q << 1;
        sh1_q <= sh1_q << 1;
      end
    end
  end

  assign d0_o  = sh0_q[WORD_W-1];
  assign d1_o  = sh1_q[WORD_W-1];
  assign par_o = par_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(d0_o) && $stable(d1_o) && $stable(par_o));
endmodule

// File: rtl/adc_out_mapper.sv
module adc_out_mapper
  import adc_map_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int CNT_W = $clog2(2 * (SMP_W + 4) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic [SMP_W-1:0] raw0_i,
  input  logic [SMP_W-1:0] raw1_i,
  input  logic [SMP_W-1:0] flt0_i,
  input  logic [SMP_W-1:0] flt1_i,
  input  logic             src_sel_i,
  input  logic [1:0]       lane_mode_i,
  input  logic [1:0]       res_sel_i,
  output logic             take_o,
  output logic             fclk_o,
  output logic             dclk_o,
  output logic             d0_o,
  output logic             d1_o,
  output logic [SMP_W-1:0] par_o
);
  localparam int WORD_W = SMP_W + 4;
  localparam int N_CH   = 2;

  lane_mode_e       mode_c, cur_mode;
  res_e             res_c;
  logic             src_c, load_c, mid_c, swap_c;
  logic [CNT_W-1:0] half_c;
  logic [SMP_W-1:0]  raw_a [N_CH];
  logic [SMP_W-1:0]  flt_a [N_CH];
  logic [WORD_W-1:0] word_a [N_CH];

  assign raw_a[0] = raw0_i;
  assign raw_a[1] = raw1_i;
  assign flt_a[0] = flt0_i;
  assign flt_a[1] = flt1_i;

  adc_map_ctrl #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .mode_i     (lane_mode_e'(lane_mode_i)),
    .res_i      (res_e'(res_sel_i)),
    .src_i      (src_sel_i),
    .mode_o     (mode_c),
    .res_o      (res_c),
    .src_o      (src_c),
    .cur_mode_o (cur_mode),
    .load_o     (load_c),
    .mid_o      (mid_c),
    .swap_o     (swap_c),
    .half_o     (half_c),
    .take_o     (take_o),
    .fclk_o     (fclk_o),
    .dclk_o     (dclk_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SMP_W-1:0] smp;
    assign smp = src_c ? flt_a[c] : raw_a[c];
    adc_map_fmt #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_fmt (
      .smp_i  (smp),
      .res_i  (res_c),
      .word_o (word_a[c])
    );
  end

  adc_map_lanes #(.SMP_W(SMP_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .load_i   (load_c),
    .mid_i    (mid_c),
    .swap_i   (swap_c),
    .mode_i   (mode_c),
    .res_i    (res_c),
    .half_i   (half_c),
    .word0_i  (word_a[0]),
    .word1_i  (word_a[1]),
    .d0_o     (d0_o),
    .d1_o     (d1_o),
    .par_o    (par_o)
  );

  p_d1_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_mode != LM_DUAL |-> !d1_o);
endmodule

// File: tb/sim_adc_out_mapper.sv
module sim_adc_out_mapper;
  logic        clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [15:0] raw0 = '0, raw1 = '0, flt0 = '0, flt1 = '0;
  logic        src = 1'b0;
  logic [1:0]  mode = 2'd1, res = 2'd1;
  logic        take, fclk, dclk, d0, d1;
  logic [15:0] par;

  adc_out_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en),
    .raw0_i(raw0), .raw1_i(raw1), .flt0_i(flt0), .flt1_i(flt1),
    .src_sel_i(src), .lane_mode_i(mode), .res_sel_i(res),
    .take_o(take), .fclk_o(fclk), .dclk_o(dclk), .d0_o(d0), .d1_o(d1), .par_o(par)
  );

  always #5 clk = ~clk;

  typedef struct {int md; int rs; logic [19:0] w; logic [15:0] p; bit s;} item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  bit en_prev = 0, fclk_prev = 0, in_fr = 0, mid_exp = 0, chg_live = 0, chg_done = 0;
  int idx = 0, hic = 0, tk = 0;
  logic b0 [64];
  logic b1 [64];
  logic [15:0] pv = '0;
  logic [20:0] snap = '0;
  int fr_md = 1, fr_rs = 1;
  bit fr_s = 0;
  int want_md = 1, want_rs = 1, en_pct = 100;
  bit want_s = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] fmt_w(input logic [15:0] s, input int rs);
    int bits = 14 + 2 * rs;
    return {s, 4'b0} & ~(20'hFFFFF >> bits);
  endfunction

  function automatic logic [15:0] par_w(input logic [15:0] s, input int rs);
    return (rs == 0) ? {2'b00, s[15:2]} : s;
  endfunction

  function automatic item_t mk(input int md, input int rs, input bit s, input logic [15:0] v);
    item_t it;
    it.md = md; it.rs = rs; it.s = s; it.w = fmt_w(v, rs); it.p = par_w(v, rs);
    return it;
  endfunction

  task automatic finish_frame(input int ntk);
    item_t a, b;
    int R, h, ln, hi;
    logic [19:0] ra, rb;
    bit quiet;
    if (q.size() == 0) begin
      chk(0, "R4", 0, 1);
      return;
    end
    a = q[0];
    R = 14 + 2 * a.rs;
    h = R / 2;
    case (a.md)
      0, 1:    begin ln = R;     hi = h; end
      2:       begin ln = 2 * R; hi = R; end
      default: begin ln = 2;     hi = 1; end
    endcase
    chk(idx == ln, chg_done ? "R6" : "R4", idx, ln);
    chk(hic == hi, "R4", hic, hi);
    chk(ntk == ((a.md == 0) ? 2 : 1), "R8", ntk, (a.md == 0) ? 2 : 1);
    quiet = 1;
    for (int i = 0; i < idx && i < 64; i++) if (b1[i] !== 1'b0) quiet = 0;
    ra = '0;
    rb = '0;
    case (a.md)
      1: begin
        void'(q.pop_front());
        for (int i = 0; i < R; i++) ra[19-i] = b0[i];
        chk(ra == a.w, a.s ? "R7" : "R1", ra, a.w);
        chk(quiet, "R2", 0, 0);
      end
      0: begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          chk(0, "R2", 0, 1);
          return;
        end
        b = q.pop_front();
        for (int i = 0; i < h; i++) begin
          ra[19-i]   = b0[i];
          ra[19-h-i] = b1[i];
          rb[19-i]   = b0[h+i];
          rb[19-h-i] = b1[h+i];
        end
        chk(ra == a.w, "R2", ra, a.w);
        chk(rb == b.w, "R2", rb, b.w);
      end
      2: begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          chk(0, "R2", 0, 1);
          return;
        end
        b = q.pop_front();
        for (int i = 0; i < R; i++) begin
          ra[19-i] = b0[i];
          rb[19-i] = b0[R+i];
        end
        chk(ra == a.w, "R2", ra, a.w);
        chk(rb == b.w, "R2", rb, b.w);
        chk(quiet, "R2", 0, 0);
      end
      default: begin
        void'(q.pop_front());
        chk(pv == a.p, "R3", pv, a.p);
      end
    endcase
  endtask

  task automatic step();
    int crs;
    @(negedge clk);
    // monitor
    if (en_prev) begin
      if (fclk && !fclk_prev) begin
        if (in_fr) finish_frame(tk - 1);
        in_fr = 1; idx = 0; hic = 0; tk = 1;
      end
      if (in_fr && idx < 64) begin
        b0[idx] = d0;
        b1[idx] = d1;
        if (fclk) hic++;
        if (idx == 0) pv = par;
        chk(dclk == !idx[0], "R5", dclk, !idx[0]);
        idx++;
      end
      fclk_prev = fclk;
    end else begin
      chk({d0, d1, fclk, dclk, par, take} == {snap[20:1], 1'b0}, "R9",
          {d0, d1, fclk, dclk, par, take}, {snap[20:1], 1'b0});
    end
    snap = {d0, d1, fclk, dclk, par, 1'b0};
    // driver
    if (int'(mode) != want_md || int'(res) != want_rs || src != want_s) begin
      chg_live = 1;
      mode = 2'(want_md);
      res  = 2'(want_rs);
      src  = want_s;
    end
    bit_en = ($urandom_range(99) < en_pct);
    raw0 = 16'($urandom); raw1 = 16'($urandom);
    flt0 = 16'($urandom); flt1 = 16'($urandom);
    en_prev = bit_en;
    #1;
    if (take) begin
      chk(bit_en, "R8", 0, 1);
      tk++;
      if (mid_exp) begin
        mid_exp = 0;
        q.push_back(mk(fr_md, fr_rs, fr_s, fr_s ? flt0 : raw0));
      end else begin
        crs = int'(res);
        if (mode == 2'd3 && crs > 1) crs = 1;
        fr_md = int'(mode); fr_rs = crs; fr_s = src;
        chg_done = chg_live; chg_live = 0;
        mid_exp = (fr_md == 0);
        q.push_back(mk(fr_md, fr_rs, fr_s, fr_s ? flt0 : raw0));
        if (fr_md == 2) q.push_back(mk(fr_md, fr_rs, fr_s, fr_s ? flt1 : raw1));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk({d0, d1, fclk, dclk} == 4'b0, "R10", {d0, d1, fclk, dclk}, 0);
    chk(par == 16'h0, "R10", par, 0);
    chk(take == 1'b0, "R10", take, 0);
    snap = '0;
    for (int md = 0; md < 4; md++)
      for (int rs = 0; rs < 4; rs++)
        for (int s = 0; s < 2; s++) begin
          want_md = md; want_rs = rs; want_s = bit'(s);
          en_pct = ((md + rs + s) % 2 == 0) ? 100 : 60;
          repeat (260) step();
        end
    // R6: bursts of mid-frame configuration changes
    en_pct = 80;
    for (int k = 0; k < 120; k++) begin
      want_md = $urandom_range(3);
      want_rs = $urandom_range(3);
      want_s  = bit'($urandom_range(1));
      repeat ($urandom_range(3, 25)) step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule